// File: doc/BRIEF.md
# Upper-Block Write Protection Gate

This block sits beside the write path of a 512-byte serial memory and rules, one byte address at a time, whether a pending write may reach the cell array. The array is split into a lower and an upper block of 256 bytes. Software can fence off the top part of the upper block. It does this by writing a boundary value and a disable flag into the last byte of the array, address 1FFh. A board-level enable pin arms that fence. A separate hardware write-control pin forbids every write, whatever the address.

The gate keeps its own copy of the byte at 1FFh. After reset the copy reads FFh, the erased value, so the fence is off. Boot logic may then load the copy with the real array contents. The copy follows every write to 1FFh that the gate itself lets through. The controller that uses the gate pulses a strobe with each target address, including every byte of a multi-byte burst. One cycle later it receives an allow flag and a reason code.

Top module: `wp_region_checker`

## Requirements
- R1: A synchronous reset sets the stored protection byte to FFh, which leaves the fence disabled. In the first cycle after reset, `res_vld_o` is low.
- R2: While `wr_ctrl_i` is high, every checked address returns allow=0 with reason code 01. A commit to 1FFh made while `wr_ctrl_i` is high leaves the stored byte unchanged.
- R3: With `prot_en_i` high and bit 2 of the stored byte at 0, an address is inhibited with reason code 10 when two conditions hold. Its bit 8 must be 1. Its bits 7..3 must be greater than or equal to bits 7..3 of the stored byte. This includes the address exactly at the boundary and the address 1FFh itself.
- R4: An address with bit 8 = 0 (lower block) is never inhibited by the fence.
- R5: An upper-block address whose bits 7..3 are below the boundary field is allowed with reason code 00.
- R6: When bit 2 of the stored byte is 1, the fence is off for every address.
- R7: While `prot_en_i` is low, the fence is off. In that state 1FFh takes commits like any other byte.
- R8: The stored byte changes only on a commit to address 1FFh that the gate would allow at that moment. Commits to other addresses have no effect on it.
- R9: A boot load overwrites the stored byte without any condition. When a boot load and a commit arrive in the same cycle, the boot load wins.
- R10: The verdict appears exactly one cycle after the strobe, with `res_vld_o` high. Allow is 1 exactly when the reason code is 00. When `res_vld_o` is low, allow and the reason code are 0.
- R11: Strobes on consecutive cycles each get their own verdict, based on their own address and on the pin levels at their own cycle.
- R12: When the write-control pin and the fence both apply, the reason code is 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_en_i | input | 1 | Arms the upper-block fence when high |
| wr_ctrl_i | input | 1 | Forbids all writes when high |
| chk_stb_i | input | 1 | Check request for `chk_addr_i` |
| chk_addr_i | input | 9 | Byte address to be judged |
| boot_ld_i | input | 1 | Loads the stored protection byte from `boot_data_i` |
| boot_data_i | input | 8 | Array contents of 1FFh read at start-up |
| commit_i | input | 1 | A byte write is being committed |
| commit_addr_i | input | 9 | Address of the committed byte |
| commit_data_i | input | 8 | Value of the committed byte |
| res_vld_o | output | 1 | Verdict valid, one cycle after the strobe |
| res_allow_o | output | 1 | 1 = write may commit |
| res_code_o | output | 2 | 00 open, 01 write-control, 10 fenced region |

## Verification
The hardest case to reach is a fence change that the gate itself must refuse: a commit to 1FFh that arrives while the fence already covers 1FFh. The stimulus first boot-loads a boundary with the flag cleared. It then commits a new value to 1FFh with the enable pin high, and again with the write-control pin high. After each commit, it probes an address that would be fenced only if the new value had been taken. The same probe, after a commit made with the enable pin low, shows that the update does take effect in that case.

// File: rtl/wp_pkg.sv
package wp_pkg;

    typedef enum logic [1:0] {
        VERDICT_OPEN   = 2'b00,
        VERDICT_WCTRL  = 2'b01,
        VERDICT_REGION = 2'b10
    } verdict_e;

    typedef struct packed {
        logic     valid;
        logic     allow;
        verdict_e code;
    } result_t;

    localparam result_t RESULT_IDLE = '{valid: 1'b0, allow: 1'b0, code: VERDICT_OPEN};

    function automatic verdict_e judge(input logic wctrl, input logic fenced);
        if (wctrl)       return VERDICT_WCTRL;
        else if (fenced) return VERDICT_REGION;
        else             return VERDICT_OPEN;
    endfunction

endpackage

// File: rtl/wp_shadow_reg.sv
module wp_shadow_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              boot_ld,
    input  logic [DATA_W-1:0] boot_data,
    input  logic              upd,
    input  logic [DATA_W-1:0] upd_data,
    output logic [DATA_W-1:0] q
);
    localparam logic [DATA_W-1:0] ERASED = '1;

    always_ff @(posedge clk) begin
        if (rst)          q <= ERASED;
        else if (boot_ld) q <= boot_data;
        else if (upd)     q <= upd_data;
    end
endmodule

// File: rtl/wp_region_cmp.sv
module wp_region_cmp #(
    parameter int ADDR_W = 9,
    parameter int ROW_W  = 3,
    parameter int DATA_W = ADDR_W - 1
) (
    input  logic [DATA_W-1:0] shadow_i,
    input  logic              prot_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              fenced_o
);
    localparam int BND_W    = ADDR_W - 1 - ROW_W;
    localparam int FLAG_BIT = ROW_W - 1;
    localparam int BLK_BIT  = ADDR_W - 1;

    logic [BND_W-1:0] boundary;
    logic [BND_W-1:0] row;
    logic             flag_off;
    logic             unused_low_bits;

    assign boundary        = shadow_i[DATA_W-1 -: BND_W];
    assign row             = addr_i[BLK_BIT-1 -: BND_W];
    assign flag_off        = shadow_i[FLAG_BIT];
    assign unused_low_bits = ^{shadow_i[FLAG_BIT-1:0], addr_i[ROW_W-1:0]};

    always_comb begin
        fenced_o = 1'b0;
        if (prot_en_i && !flag_off && addr_i[BLK_BIT])
            fenced_o = (row >= boundary);
    end
endmodule

// File: rtl/wp_region_checker.sv
module wp_region_checker #(
    parameter int ADDR_W = 9,
    parameter int ROW_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_en_i,
    input  logic              wr_ctrl_i,
    input  logic              chk_stb_i,
    input  logic [ADDR_W-1:0] chk_addr_i,
    input  logic              boot_ld_i,
    input  logic [ADDR_W-2:0] boot_data_i,
    input  logic              commit_i,
    input  logic [ADDR_W-1:0] commit_addr_i,
    input  logic [ADDR_W-2:0] commit_data_i,
    output logic              res_vld_o,
    output logic              res_allow_o,
    output logic [1:0]        res_code_o
);
    import wp_pkg::*;

    localparam int                DATA_W   = ADDR_W - 1;
    localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

    logic [DATA_W-1:0] shadow;
    logic              chk_fenced;
    logic              cmt_fenced;
    logic              cmt_take;
    verdict_e          chk_verdict;
    result_t           res_q;

    wp_region_cmp #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_cmp_chk (
        .shadow_i (shadow),
        .prot_en_i(prot_en_i),
        .addr_i   (chk_addr_i),
        .fenced_o (chk_fenced)
    );

    wp_region_cmp #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .DATA_W(DATA_W)) u_cmp_cmt (
        .shadow_i (shadow),
        .prot_en_i(prot_en_i),
        .addr_i   (commit_addr_i),
        .fenced_o (cmt_fenced)
    );

    assign cmt_take = commit_i && (commit_addr_i == TOP_ADDR)
                      && (judge(wr_ctrl_i, cmt_fenced) == VERDICT_OPEN);

    wp_shadow_reg #(.DATA_W(DATA_W)) u_shadow (
        .clk      (clk),
        .rst      (rst),
        .boot_ld  (boot_ld_i),
        .boot_data(boot_data_i),
        .upd      (cmt_take),
        .upd_data (commit_data_i),
        .q        (shadow)
    );

    assign chk_verdict = judge(wr_ctrl_i, chk_fenced);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= RESULT_IDLE;
        end else if (chk_stb_i) begin
            res_q.valid <= 1'b1;
            res_q.allow <= (chk_verdict == VERDICT_OPEN);
            res_q.code  <= chk_verdict;
        end else begin
            res_q <= RESULT_IDLE;
        end
    end

    assign res_vld_o   = res_q.valid;
    assign res_allow_o = res_q.allow;
    assign res_code_o  = res_q.code;
endmodule

// File: rtl/wp_region_checker_sva.sv
module wp_region_checker_sva #(
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst,
    input logic              prot_en_i,
    input logic              wr_ctrl_i,
    input logic              chk_stb_i,
    input logic [ADDR_W-1:0] chk_addr_i,
    input logic              res_vld_o,
    input logic              res_allow_o,
    input logic [1:0]        res_code_o
);
    AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (rst)
        chk_stb_i |=> res_vld_o);                                              // R10
    AST_NO_STROBE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !chk_stb_i |=> !res_vld_o);                                            // R10
    AST_ALLOW_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
        res_vld_o |-> (res_allow_o == (res_code_o == 2'b00)));                 // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !res_vld_o |-> (!res_allow_o && res_code_o == 2'b00));                 // R10
    AST_WCTRL_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (chk_stb_i && wr_ctrl_i) |=> (!res_allow_o && res_code_o == 2'b01));   // R2
    AST_LOWER_BLOCK_OPEN: assert property (@(posedge clk) disable iff (rst)
        (chk_stb_i && !wr_ctrl_i && !chk_addr_i[ADDR_W-1]) |=> res_allow_o);   // R4
    AST_PIN_LOW_OPEN: assert property (@(posedge clk) disable iff (rst)
        (chk_stb_i && !wr_ctrl_i && !prot_en_i) |=> res_allow_o);              // R7
endmodule

bind wp_region_checker wp_region_checker_sva #(.ADDR_W(ADDR_W)) u_sva (
    .clk        (clk),
    .rst        (rst),
    .prot_en_i  (prot_en_i),
    .wr_ctrl_i  (wr_ctrl_i),
    .chk_stb_i  (chk_stb_i),
    .chk_addr_i (chk_addr_i),
    .res_vld_o  (res_vld_o),
    .res_allow_o(res_allow_o),
    .res_code_o (res_code_o)
);

// File: tb/wp_region_checker_bench.sv
`timescale 1ns/1ps
module wp_region_checker_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prot_en_i = 1'b0;
    logic       wr_ctrl_i = 1'b0;
    logic       chk_stb_i = 1'b0;
    logic [8:0] chk_addr_i = '0;
    logic       boot_ld_i = 1'b0;
    logic [7:0] boot_data_i = '0;
    logic       commit_i = 1'b0;
    logic [8:0] commit_addr_i = '0;
    logic [7:0] commit_data_i = '0;
    logic       res_vld_o;
    logic       res_allow_o;
    logic [1:0] res_code_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wp_region_checker u_wp_region_checker (
        .clk(clk), .rst(rst), .prot_en_i(prot_en_i), .wr_ctrl_i(wr_ctrl_i),
        .chk_stb_i(chk_stb_i), .chk_addr_i(chk_addr_i),
        .boot_ld_i(boot_ld_i), .boot_data_i(boot_data_i),
        .commit_i(commit_i), .commit_addr_i(commit_addr_i), .commit_data_i(commit_data_i),
        .res_vld_o(res_vld_o), .res_allow_o(res_allow_o), .res_code_o(res_code_o)
    );

    // layout: {pe, wc, addr[8:0], exp_allow, exp_code[1:0]}; boundary 0xA0, flag 0
    localparam int NV = 11;
    localparam logic [13:0] VEC [NV] = '{
        {1'b1, 1'b0, 9'h1A0, 1'b0, 2'd2},  // R3 exact boundary
        {1'b1, 1'b0, 9'h19F, 1'b1, 2'd0},  // R5 just below
        {1'b1, 1'b0, 9'h1FF, 1'b0, 2'd2},  // R3 top byte
        {1'b1, 1'b0, 9'h0FF, 1'b1, 2'd0},  // R4
        {1'b1, 1'b0, 9'h0A0, 1'b1, 2'd0},  // R4
        {1'b0, 1'b0, 9'h1FF, 1'b1, 2'd0},  // R7
        {1'b1, 1'b1, 9'h050, 1'b0, 2'd1},  // R2
        {1'b1, 1'b1, 9'h1B0, 1'b0, 2'd1},  // R12
        {1'b0, 1'b1, 9'h100, 1'b0, 2'd1},  // R2
        {1'b1, 1'b0, 9'h1A7, 1'b0, 2'd2},  // R3
        {1'b1, 1'b0, 9'h100, 1'b1, 2'd0}   // R5
    };

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual {vld,allow,code}=%b expected %b", req, act, exp);
        end
    endtask

    task automatic probe(input string req, input logic pe, input logic wc,
                         input logic [8:0] a, input logic allow, input logic [1:0] code);
        @(negedge clk);
        prot_en_i = pe; wr_ctrl_i = wc; chk_addr_i = a; chk_stb_i = 1'b1;
        @(negedge clk);
        chk_stb_i = 1'b0;
        check(req, {res_vld_o, res_allow_o, res_code_o}, {1'b1, allow, code});
    endtask

    task automatic boot(input logic [7:0] d);
        @(negedge clk);
        boot_ld_i = 1'b1; boot_data_i = d;
        @(negedge clk);
        boot_ld_i = 1'b0;
    endtask

    task automatic commit(input logic pe, input logic wc, input logic [8:0] a, input logic [7:0] d);
        @(negedge clk);
        prot_en_i = pe; wr_ctrl_i = wc; commit_i = 1'b1; commit_addr_i = a; commit_data_i = d;
        @(negedge clk);
        commit_i = 1'b0; wr_ctrl_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", {res_vld_o, res_allow_o, res_code_o}, 4'b0000);
        probe("R1 erased byte leaves fence off", 1'b1, 1'b0, 9'h1FF, 1'b1, 2'd0);

        // table: back-to-back strobes, one verdict per cycle (R11)
        boot(8'hA0);
        for (int i = 0; i <= NV; i++) begin
            @(negedge clk);
            if (i > 0)
                check($sformatf("R11 vector %0d", i - 1),
                      {res_vld_o, res_allow_o, res_code_o},
                      {1'b1, VEC[i-1][2], VEC[i-1][1:0]});
            if (i < NV) begin
                prot_en_i  = VEC[i][13];
                wr_ctrl_i  = VEC[i][12];
                chk_addr_i = VEC[i][11:3];
                chk_stb_i  = 1'b1;
            end else begin
                chk_stb_i = 1'b0; wr_ctrl_i = 1'b0;
            end
        end
        @(negedge clk);
        check("R10 valid drops without strobe", {res_vld_o, res_allow_o, res_code_o}, 4'b0000);

        // R6: flag bit 2 set disables fence
        boot(8'hA4);
        probe("R6 flag set, top byte open", 1'b1, 1'b0, 9'h1FF, 1'b1, 2'd0);

        // R8: commit to fenced 1FFh refused
        boot(8'hA0);
        commit(1'b1, 1'b0, 9'h1FF, 8'h00);
        probe("R8 refused commit keeps boundary", 1'b1, 1'b0, 9'h100, 1'b1, 2'd0);
        // R2: commit under write-control refused, even with pin low
        commit(1'b0, 1'b1, 9'h1FF, 8'h00);
        probe("R2 write-control commit ignored", 1'b1, 1'b0, 9'h100, 1'b1, 2'd0);
        // R8: commit elsewhere ignored
        commit(1'b0, 1'b0, 9'h0FF, 8'h00);
        probe("R8 other address ignored", 1'b1, 1'b0, 9'h100, 1'b1, 2'd0);
        // R7: pin low, 1FFh writable
        commit(1'b0, 1'b0, 9'h1FF, 8'h00);
        probe("R7 top byte written with pin low", 1'b1, 1'b0, 9'h100, 1'b0, 2'd2);
        probe("R4 lower block still open", 1'b1, 1'b0, 9'h0FF, 1'b1, 2'd0);

        // R9: boot beats same-cycle commit
        @(negedge clk);
        prot_en_i = 1'b0; boot_ld_i = 1'b1; boot_data_i = 8'hFF;
        commit_i = 1'b1; commit_addr_i = 9'h1FF; commit_data_i = 8'h00;
        @(negedge clk);
        boot_ld_i = 1'b0; commit_i = 1'b0;
        probe("R9 boot load wins", 1'b1, 1'b0, 9'h100, 1'b1, 2'd0);

        // R1: reset restores erased byte
        boot(8'h00);
        probe("R3 zero boundary fences 100h", 1'b1, 1'b0, 9'h100, 1'b0, 2'd2);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        probe("R1 reset reopens fence", 1'b1, 1'b0, 9'h1FF, 1'b1, 2'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule